// File: doc/BRIEF.md
# Recirculating Serial Page Buffer

This block is the one-page holding register that sits between a bit-serial command port and a memory array. It stores one page of 256 bits. Software-facing logic starts a serial transfer into or out of the page with a one-cycle start pulse and an 8-bit argument that is the bit count minus one. The transfer then moves one bit on each qualified clock-enable strobe, and a done pulse marks its completion.

The storage is a ring. An outgoing bit leaves from the top of the ring and re-enters at the bottom. A read therefore never destroys data, and a partial read or write advances the ring position. Bits arrive first-in first-out. The whole page can be replaced from the array in one cycle, and the current contents are always visible in parallel for programming into the array. A busy-lock input freezes all serial movement while the array owns the page.

Top module: `page_ring_buf`

## Requirements
- R1: After reset the page contents read all zeros on `dump_data` and `xfer_done` is low.
- R2: A transfer started with argument N moves exactly N+1 bits. `xfer_done` goes high for exactly one cycle, in the cycle after the clock edge that moves the last bit.
- R3: On a write transfer, each moved bit enters at position 0 and every other bit moves up by one. After 256 bits, the first bit written sits at position 255.
- R4: On a read transfer, `ser_out` presents position 255. Each moved bit re-enters at position 0, so a 256-bit read leaves the page unchanged, and a shorter read leaves it rotated by the number of bits moved.
- R5: Writing only 40 bits and then reading 256 bits returns the 216 bits that were in positions 215..0 before the write, followed by the 40 new bits.
- R6: While `busy_lock` is high, start pulses are ignored, strobes move no bit and are not counted, and the page contents hold.
- R7: Cycles with `bit_en` low move no bit and do not advance the transfer count.
- R8: A high `ld_en` replaces all 256 bits with `ld_data` in one cycle. It takes precedence over any strobe in that cycle, and such a strobe is not counted.
- R9: `dump_data` always shows the full current page, with position 255 in its most significant bit.
- R10: Strobes that arrive while no transfer is active leave the page unchanged and raise no done pulse.
- R11: A start pulse during an active transfer is ignored. If both start pulses arrive together on an idle buffer, a write transfer begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | Clock-enable strobe; one bit moves per qualified strobe |
| ser_in | input | 1 | Serial data into the page |
| ser_out | output | 1 | Serial data out of the page (position 255) |
| xfer_cnt | input | 8 | Transfer argument, bit count minus one |
| start_in | input | 1 | Pulse that begins a write transfer |
| start_out | input | 1 | Pulse that begins a read transfer |
| xfer_done | output | 1 | One-cycle pulse when the last bit has moved |
| ld_en | input | 1 | Parallel load of the whole page |
| ld_data | input | 256 | Page image from the array |
| dump_data | output | 256 | Current page image toward the array |
| busy_lock | input | 1 | Freezes serial movement and starts while high |

## Verification
The hardest condition to reach from the ports is a transfer that is interrupted in the middle. This means strobes that land while `busy_lock` is high, idle gaps, and a second start pulse arriving partway through, all after which the count must still stop at exactly N+1 bits. The stimulus starts a write, pairs each real bit with a locked strobe that carries the inverted bit value, and inserts empty cycles between strobes. It also fires a conflicting read start on the first strobe of another transfer. A bench model of the ring then predicts both the page image and every bit that a later full read returns through the scoreboard.

// File: rtl/prb_pkg.sv
package prb_pkg;

  typedef enum logic {
    DIR_IN  = 1'b0,
    DIR_OUT = 1'b1
  } prb_dir_e;

  // Number of bits a transfer moves for a given argument.
  function automatic int unsigned prb_bits_of(input int unsigned arg);
    return arg + 1;
  endfunction

  // Ring image after one recirculating step with the given entry bit.
  function automatic logic [255:0] prb_step256(input logic [255:0] img, input logic b);
    return {img[254:0], b};
  endfunction

endpackage

// File: rtl/prb_ctrl.sv
module prb_ctrl
  import prb_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             busy_lock,
  input  logic             ld_en,
  input  logic             start_in,
  input  logic             start_out,
  input  logic [CNT_W-1:0] xfer_cnt,
  output logic             shift_in_ev,
  output logic             shift_out_ev,
  output logic             active,
  output logic             xfer_done
);

  localparam int unsigned MOVED_W = CNT_W + 1;

  prb_dir_e         dir_q;
  logic [CNT_W-1:0] remain_q;
  logic [CNT_W-1:0] arg_q;
  logic             strobe_ok;
  logic             start_ok;
  logic             last_bit;

  assign strobe_ok    = active && bit_en && !busy_lock && !ld_en;
  assign start_ok     = !active && !busy_lock && (start_in || start_out);
  assign last_bit     = (remain_q == '0);
  assign shift_in_ev  = strobe_ok && (dir_q == DIR_IN);
  assign shift_out_ev = strobe_ok && (dir_q == DIR_OUT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      dir_q     <= DIR_IN;
      remain_q  <= '0;
      arg_q     <= '0;
      xfer_done <= 1'b0;
    end else begin
      xfer_done <= strobe_ok && last_bit;
      if (start_ok) begin
        active   <= 1'b1;
        dir_q    <= start_in ? DIR_IN : DIR_OUT;
        remain_q <= xfer_cnt;
        arg_q    <= xfer_cnt;
      end else if (strobe_ok) begin
        if (last_bit) active <= 1'b0;
        else          remain_q <= remain_q - 1'b1;
      end
    end
  end

  // Independent tally of moved bits, for the count property.
  logic [MOVED_W-1:0] moved_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         moved_q <= '0;
    else if (start_ok)  moved_q <= '0;
    else if (strobe_ok) moved_q <= moved_q + 1'b1;
  end

  // R2: the final move is exactly the (arg+1)th one
  p_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_ok && last_bit) |-> (32'(moved_q) + 1 == prb_bits_of(32'(arg_q))));

  // R2: done lasts one cycle
  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);

  // R2: done only follows an active transfer
  p_done_after_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_done) |-> $fell(active));

  // R6: lock freezes a running transfer
  p_lock_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && busy_lock) |=> (active && $stable(remain_q)));

  // R6: no transfer begins under lock
  p_lock_nostart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && busy_lock) |=> !active);

  // R7: idle strobe slots do not advance the count
  p_gap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !bit_en) |=> (active && $stable(remain_q)));

  // R11: a start during a transfer does not reload it
  p_no_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !strobe_ok) |=> ($stable(arg_q) && $stable(dir_q)));

endmodule

// File: rtl/prb_ring.sv
module prb_ring #(
  parameter int unsigned PAGE_BITS = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift_in_ev,
  input  logic                 shift_out_ev,
  input  logic                 ser_in,
  input  logic                 ld_en,
  input  logic [PAGE_BITS-1:0] ld_data,
  output logic [PAGE_BITS-1:0] ring_q,
  output logic                 top_bit
);

  localparam int unsigned TOP = PAGE_BITS - 1;

  logic [PAGE_BITS-1:0] ring_d;
  logic                 entry_bit;
  logic                 move;

  assign top_bit   = ring_q[TOP];
  assign move      = shift_in_ev || shift_out_ev;
  assign entry_bit = shift_out_ev ? ring_q[TOP] : ser_in;

  // One cell per page bit; each takes its lower neighbour on a move.
  for (genvar g = 0; g < PAGE_BITS; g++) begin : g_cell
    if (g == 0) begin : g_entry
      always_comb begin
        if (ld_en)     ring_d[g] = ld_data[g];
        else if (move) ring_d[g] = entry_bit;
        else           ring_d[g] = ring_q[g];
      end
    end else begin : g_body
      always_comb begin
        if (ld_en)     ring_d[g] = ld_data[g];
        else if (move) ring_d[g] = ring_q[g-1];
        else           ring_d[g] = ring_q[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ring_q <= '0;
    else        ring_q <= ring_d;
  end

  // R8: whole page replaced in one cycle
  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (ring_q == $past(ld_data)));

  // R3: a written bit lands at position 0, the rest move up
  p_shift_in_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_in_ev && !ld_en) |=> ((ring_q[0] == $past(ser_in)) &&
                                 (ring_q[TOP:1] == $past(ring_q[TOP-1:0]))));

  // R4: a read bit re-enters at position 0
  p_rotate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_out_ev && !ld_en) |=> (ring_q[0] == $past(ring_q[TOP])));

  // R10: no event, no change
  p_quiet_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_in_ev && !shift_out_ev && !ld_en) |=> $stable(ring_q));

endmodule

// File: rtl/page_ring_buf.sv
module page_ring_buf
  import prb_pkg::*;
#(
  parameter int unsigned PAGE_BITS = 256,
  parameter int unsigned CNT_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_en,
  input  logic                 ser_in,
  output logic                 ser_out,
  input  logic [CNT_W-1:0]     xfer_cnt,
  input  logic                 start_in,
  input  logic                 start_out,
  output logic                 xfer_done,
  input  logic                 ld_en,
  input  logic [PAGE_BITS-1:0] ld_data,
  output logic [PAGE_BITS-1:0] dump_data,
  input  logic                 busy_lock
);

  logic shift_in_ev;
  logic shift_out_ev;
  logic active;
  logic top_bit;

  prb_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_en       (bit_en),
    .busy_lock    (busy_lock),
    .ld_en        (ld_en),
    .start_in     (start_in),
    .start_out    (start_out),
    .xfer_cnt     (xfer_cnt),
    .shift_in_ev  (shift_in_ev),
    .shift_out_ev (shift_out_ev),
    .active       (active),
    .xfer_done    (xfer_done)
  );

  prb_ring #(.PAGE_BITS(PAGE_BITS)) ring_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .shift_in_ev  (shift_in_ev),
    .shift_out_ev (shift_out_ev),
    .ser_in       (ser_in),
    .ld_en        (ld_en),
    .ld_data      (ld_data),
    .ring_q       (dump_data),
    .top_bit      (top_bit)
  );

  assign ser_out = top_bit;

  // R6: page frozen under lock
  p_lock_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_lock && !ld_en) |=> $stable(dump_data));

  // R10: strobes with no transfer do nothing
  p_idle_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !ld_en) |=> $stable(dump_data));

  // R4: serial output is the top of the page
  p_out_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ser_out == dump_data[PAGE_BITS-1]);

  // Never both directions at once
  p_one_dir_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({shift_in_ev, shift_out_ev}));

endmodule

// File: tb/page_ring_buf_tb_top.sv
module page_ring_buf_tb_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bit_en = 1'b0;
  logic         ser_in = 1'b0;
  logic         ser_out;
  logic [7:0]   xfer_cnt = '0;
  logic         start_in = 1'b0;
  logic         start_out = 1'b0;
  logic         xfer_done;
  logic         ld_en = 1'b0;
  logic [255:0] ld_data = '0;
  logic [255:0] dump_data;
  logic         busy_lock = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  logic [255:0] mdl = '0;
  logic         exp_q[$];
  logic         out_phase = 1'b0;
  bit           finished = 1'b0;

  always #4 clk = ~clk;

  page_ring_buf dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ser_in(ser_in),
    .ser_out(ser_out), .xfer_cnt(xfer_cnt), .start_in(start_in),
    .start_out(start_out), .xfer_done(xfer_done), .ld_en(ld_en),
    .ld_data(ld_data), .dump_data(dump_data), .busy_lock(busy_lock)
  );

  task automatic chk(input bit ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Monitor: pops the expected read bit for every qualified read strobe.
  always @(negedge clk) begin
    if (out_phase && bit_en && !busy_lock && !ld_en) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 scoreboard underflow", 256'(ser_out), '0);
      end else begin
        logic e;
        e = exp_q.pop_front();
        chk(ser_out == e, "R4/R5 serial read bit", 256'(ser_out), 256'(e));
      end
    end
  end

  // Driver: one complete transfer, optionally with idle gaps between strobes.
  task automatic run_xfer(input bit dir, input int cnt, input logic [255:0] src,
                          input bit gaps, input string req);
    xfer_cnt = cnt[7:0];
    if (dir) start_out = 1'b1; else start_in = 1'b1;
    step();
    start_in = 1'b0; start_out = 1'b0;
    out_phase = dir;
    for (int i = 0; i <= cnt; i++) begin
      if (gaps && i > 0) begin
        bit_en = 1'b0;
        step();
        chk(xfer_done == 1'b0, "R7 no done during gap", 256'(xfer_done), '0);
      end
      if (dir) begin
        exp_q.push_back(mdl[255]);
        mdl = {mdl[254:0], mdl[255]};
      end else begin
        ser_in = src[255 - i];
        mdl = {mdl[254:0], src[255 - i]};
      end
      bit_en = 1'b1;
      step();
      if (i < cnt)
        chk(xfer_done == 1'b0, "R2 no early done", 256'(xfer_done), '0);
    end
    bit_en = 1'b0;
    out_phase = 1'b0;
    chk(xfer_done == 1'b1, "R2 done after last bit", 256'(xfer_done), 256'(1));
    chk(dump_data == mdl, req, dump_data, mdl);
    chk(exp_q.size() == 0, "R4 scoreboard drained", 256'(exp_q.size()), '0);
    step();
    chk(xfer_done == 1'b0, "R2 done one cycle", 256'(xfer_done), '0);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog expired", '0, '0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [255:0] pat_a, pat_b, pat_c, snap;
    pat_a = {8{32'hA5C3_0F96}} ^ {64{4'h3}};
    pat_b = {16{16'h1E2D}};
    pat_c = {256{1'b0}} | {216'd0, 40'hC3_5A_F0_0F_99};

    repeat (3) step();
    // R1: reset state
    chk(dump_data == '0, "R1 page zero after reset", dump_data, '0);
    chk(xfer_done == 1'b0, "R1 done low after reset", 256'(xfer_done), '0);
    rst_n = 1'b1;
    step();

    // R3, R9: full write, first bit at top
    run_xfer(1'b0, 255, pat_a, 1'b0, "R3 full write image");
    chk(dump_data == pat_a, "R9 dump equals written page", dump_data, pat_a);

    // R4: full read leaves page intact
    run_xfer(1'b1, 255, '0, 1'b0, "R4 full read restores page");
    chk(dump_data == pat_a, "R4 page unchanged", dump_data, pat_a);

    // R8: parallel load
    ld_data = pat_b; ld_en = 1'b1;
    step();
    ld_en = 1'b0;
    mdl = pat_b;
    chk(dump_data == pat_b, "R8 parallel load", dump_data, pat_b);

    // R5: partial write of 40 bits, then a full read
    run_xfer(1'b0, 39, {pat_c[39:0], 216'd0}, 1'b0, "R5 partial write image");
    chk(dump_data == {pat_b[215:0], pat_c[39:0]}, "R5 old bits above new",
        dump_data, {pat_b[215:0], pat_c[39:0]});
    run_xfer(1'b1, 255, '0, 1'b0, "R5 full read after partial write");

    // R4: partial read rotates by 32
    snap = dump_data;
    run_xfer(1'b1, 31, '0, 1'b1, "R4 partial read rotation");
    chk(dump_data == {snap[223:0], snap[255:224]}, "R4 rotated by 32",
        dump_data, {snap[223:0], snap[255:224]});

    // R6: start under lock is ignored, later strobes are idle (R10)
    snap = dump_data;
    busy_lock = 1'b1; start_out = 1'b1; xfer_cnt = 8'd5;
    step();
    start_out = 1'b0; bit_en = 1'b1;
    step(); step();
    busy_lock = 1'b0;
    step(); step(); step();
    bit_en = 1'b0;
    chk(dump_data == snap, "R6 locked start ignored", dump_data, snap);
    chk(xfer_done == 1'b0, "R10 idle strobes no done", 256'(xfer_done), '0);
    step();
    chk(xfer_done == 1'b0, "R10 still no done", 256'(xfer_done), '0);

    // R6, R7: write of 8 bits with locked strobes carrying wrong data
    xfer_cnt = 8'd7; start_in = 1'b1;
    step();
    start_in = 1'b0;
    for (int i = 0; i < 8; i++) begin
      logic b;
      b = (i % 3 == 0);
      busy_lock = 1'b1; bit_en = 1'b1; ser_in = ~b;
      step();
      chk(dump_data == mdl, "R6 locked strobe holds page", dump_data, mdl);
      busy_lock = 1'b0; bit_en = 1'b0;
      step();
      chk(xfer_done == 1'b0, "R7 no done before last bit", 256'(xfer_done), '0);
      bit_en = 1'b1; ser_in = b;
      mdl = {mdl[254:0], b};
      step();
    end
    bit_en = 1'b0;
    chk(xfer_done == 1'b1, "R6 done after 8 real bits", 256'(xfer_done), 256'(1));
    chk(dump_data == mdl, "R6 page after locked write", dump_data, mdl);
    step();

    // R11: conflicting read start during a 4-bit write is ignored
    xfer_cnt = 8'd3; start_in = 1'b1;
    step();
    start_in = 1'b0;
    for (int i = 0; i < 4; i++) begin
      start_out = (i == 0); xfer_cnt = (i == 0) ? 8'd200 : 8'd3;
      bit_en = 1'b1; ser_in = i[0];
      mdl = {mdl[254:0], i[0]};
      step();
    end
    start_out = 1'b0; bit_en = 1'b0;
    chk(xfer_done == 1'b1, "R11 transfer ends after 4", 256'(xfer_done), 256'(1));
    chk(dump_data == mdl, "R11 write kept direction", dump_data, mdl);
    step();

    // R11: both starts together begin a write of one bit
    xfer_cnt = 8'd0; start_in = 1'b1; start_out = 1'b1;
    step();
    start_in = 1'b0; start_out = 1'b0;
    bit_en = 1'b1; ser_in = ~mdl[255];
    mdl = {mdl[254:0], ~mdl[255]};
    step();
    bit_en = 1'b0;
    chk(xfer_done == 1'b1, "R11 single-bit done", 256'(xfer_done), 256'(1));
    chk(dump_data == mdl, "R11 simultaneous start writes", dump_data, mdl);
    step();

    // R8: load wins over a strobe in the same cycle, strobe not counted
    xfer_cnt = 8'd1; start_in = 1'b1;
    step();
    start_in = 1'b0;
    ld_data = pat_a; ld_en = 1'b1; bit_en = 1'b1; ser_in = 1'b1;
    step();
    ld_en = 1'b0;
    mdl = pat_a;
    chk(dump_data == pat_a, "R8 load beats strobe", dump_data, pat_a);
    chk(xfer_done == 1'b0, "R8 strobe not counted", 256'(xfer_done), '0);
    ser_in = 1'b0; mdl = {mdl[254:0], 1'b0};
    step();
    ser_in = 1'b1; mdl = {mdl[254:0], 1'b1};
    step();
    bit_en = 1'b0;
    chk(xfer_done == 1'b1, "R8 two bits after load", 256'(xfer_done), 256'(1));
    chk(dump_data == mdl, "R8 page after load and write", dump_data, mdl);
    step();

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule